// File: doc/BRIEF.md
# Byte-Wide SPI Slave with Buffered Transmit and Receive

This block is an SPI slave peripheral that works entirely on the system clock. The external serial clock, data-in and slave-select lines are oversampled through synchronizer flops, and edges on them are found in the system clock domain. Bytes move MSB first in clock-polarity-0 / phase-0 timing. The master's data is sampled on the rising serial-clock edge. The slave's output bit changes on the falling edge.

A small register port serves the host processor. A write to the data register queues a byte for transmission. That byte enters the shift register at once when the shift register is free, or otherwise waits in a one-byte holding buffer until the current or next byte finishes. A read of the data register returns the last captured byte and releases the receive buffer. The control register holds the enable bit, the interrupt enable, the two-bit mode field and three sticky flags: byte done, write collision and receive overrun. In the default 4-wire mode the slave-select line gates the slave, and its falling edge realigns the bit counter. In 3-wire mode slave-select is ignored, and only a disable/enable cycle realigns the counter.

Top module: `spiSlave`

## Requirements
- R1: After reset the control register reads 0x04 (mode field bits [3:2] = 01, all other bits 0), `irq` is 0 and `misoEn` is 0. Control register layout: bit7 done, bit6 collision, bit5 overrun, bit4 interrupt enable, bits[3:2] mode, bit1 transmit-buffer-full (read only), bit0 enable. `wrAddr`/`rdAddr` 0 select the data register and 1 selects the control register.
- R2: When the slave is active, the eighth rising serial-clock edge completes a byte. The byte, sampled MSB first, is copied to the receive buffer and the done flag (bit7) is set.
- R3: A data-register write while the shift register is empty and no byte is in progress goes straight into the shift register. Its MSB appears on `misoOut` before the first rising edge, and each falling edge inside the byte moves to the next lower bit.
- R4: A data-register write while the shift register is occupied goes to the holding buffer and sets bit1. The held byte is loaded into the shift register when the next byte completes, which clears bit1, and that byte is sent in the following transfer.
- R5: A data-register write while bit1 is set sets the collision flag (bit6) and leaves the held byte unchanged.
- R6: When a byte completes while the receive buffer is still unread, the overrun flag (bit5) is set, the new byte is dropped and the old byte stays readable.
- R7: With a nonzero mode and `nssIn` high, the slave is inactive. `misoEn` is 0, and serial-clock edges neither count bits nor complete bytes.
- R8: In a nonzero mode, a falling edge of `nssIn` resets the bit counter, so a partial byte is discarded.
- R9: In mode 00 `nssIn` is ignored and `misoEn` follows the enable bit. A partial byte stays counted until the enable bit is written 0 and then 1, which restarts the count.
- R10: Flags are cleared only by a control write carrying 0 in the flag's bit. Writing 1 leaves the flag as it is. `irq` is 1 exactly when interrupt enable is set and any flag is set.
- R11: With the enable bit 0, `misoEn` is 0 and serial-clock activity neither sets flags nor changes the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the master, asynchronous |
| mosiIn | input | 1 | Serial data from the master, asynchronous |
| nssIn | input | 1 | Slave select, active low, asynchronous |
| misoOut | output | 1 | Serial data to the master (MSB of the shift register) |
| misoEn | output | 1 | Output enable for the external data-out pad driver |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 1 | Host write address: 0 data, 1 control |
| wrData | input | DW | Host write data |
| rdEn | input | 1 | Host read strobe; a data read releases the receive buffer |
| rdAddr | input | 1 | Host read address: 0 data, 1 control |
| rdData | output | DW | Host read data for `rdAddr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest conditions to reach are those where the bit counter is out of step with the master. They are a partial byte cut off by slave-select in 4-wire mode, and a partial byte in 3-wire mode that survives a slave-select toggle and is cleared only by an enable cycle. The bench produces them with a serial-clock task that sends only the top few bits of a pattern. It then changes the select line or the enable bit before the rest of the bits arrive. The expected received byte is built by concatenating the bit fragments. Collision and overrun are reached by queueing two and three bytes in a row, and by running two transfers without reading the receive buffer.

// File: rtl/spiSlvPkg.sv
package spiSlvPkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;      // latch data-in bit on a rising serial-clock edge
    logic shiftOut;     // advance shift register on a falling edge
    logic loadFromTx;   // holding buffer -> shift register
    logic loadFromCpu;  // host write -> shift register
    logic writeTxBuf;   // host write -> holding buffer
    logic captureRx;    // completed byte -> receive buffer
  } spiStrobeT;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam logic [1:0] MODE_THREE_WIRE = 2'b00;
  localparam logic [1:0] MODE_FOUR_WIRE  = 2'b01;

endpackage

// File: rtl/spiSlvData.sv
module spiSlvData
  import spiSlvPkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sckIn,
  input  logic          mosiIn,
  input  logic          nssIn,
  input  spiStrobeT     strb,
  input  logic [DW-1:0] cpuData,
  output logic          sckRise,
  output logic          sckFall,
  output logic          nssFall,
  output logic          nssLvl,
  output logic          misoBit,
  output logic [DW-1:0] rxWord
);

  logic [SYNC-1:0] sckSh, mosiSh, nssSh;
  logic            sckPrev, nssPrev, mosiHold;
  logic [DW-1:0]   shReg, txBuf, rxBuf;
  logic            sckS, mosiS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh   <= '0;
      mosiSh  <= '0;
      nssSh   <= '1;
      sckPrev <= 1'b0;
      nssPrev <= 1'b1;
    end else begin
      sckSh   <= {sckSh[SYNC-2:0], sckIn};
      mosiSh  <= {mosiSh[SYNC-2:0], mosiIn};
      nssSh   <= {nssSh[SYNC-2:0], nssIn};
      sckPrev <= sckS;
      nssPrev <= nssLvl;
    end
  end

  assign sckS    = sckSh[SYNC-1];
  assign mosiS   = mosiSh[SYNC-1];
  assign nssLvl  = nssSh[SYNC-1];
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign nssFall = ~nssLvl & nssPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mosiHold <= 1'b0;
      shReg    <= '0;
      txBuf    <= '0;
      rxBuf    <= '0;
    end else begin
      if (strb.shiftIn) mosiHold <= mosiS;
      if (strb.loadFromTx)       shReg <= txBuf;
      else if (strb.loadFromCpu) shReg <= cpuData;
      else if (strb.shiftOut)    shReg <= {shReg[DW-2:0], mosiHold};
      if (strb.writeTxBuf) txBuf <= cpuData;
      if (strb.captureRx)  rxBuf <= {shReg[DW-2:0], mosiS};
    end
  end

  assign misoBit = shReg[DW-1];
  assign rxWord  = rxBuf;

  // R4: the shift register has at most one source per cycle
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadFromTx, strb.loadFromCpu, strb.shiftOut}));

  // R2: a byte is captured only on a detected rising edge
  a_r2_capture_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRx |-> sckRise);

  // R5: the holding buffer is never written while it still holds a byte
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeTxBuf && $past(strb.writeTxBuf)) |-> 1'b0);

endmodule

// File: rtl/spiSlvCtrl.sv
module spiSlvCtrl
  import spiSlvPkg::*;
#(
  parameter int DW = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       nssFall,
  input  logic       nssLvl,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [6:0] ctlBits,   // {done, wcol, ovr, ie, mode[1:0], en}
  input  logic       rdEn,
  input  logic       rdAddr,
  output spiStrobeT  strb,
  output logic [7:0] ctrlWord,
  output logic       active,
  output logic       irq
);

  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          enReg, ieReg, doneF, wcolF, ovrF;
  logic [1:0]    modeReg;
  logic          rxFull, txFull, shEmpty;
  logic [CW-1:0] bitCnt;
  logic threeWire, rise, fall, complete, cpuTx, cpuCtl, rxPop, collide;

  assign threeWire = (modeReg == MODE_THREE_WIRE);
  assign active    = enReg & (threeWire | ~nssLvl);
  assign rise      = active & sckRise;
  assign fall      = active & sckFall;
  assign complete  = rise & (bitCnt == LAST);
  assign cpuTx     = wrEn & (wrAddr == ADDR_DATA);
  assign cpuCtl    = wrEn & (wrAddr == ADDR_CTRL);
  assign rxPop     = rdEn & (rdAddr == ADDR_DATA);
  assign collide   = cpuTx & txFull;

  always_comb begin
    strb             = '0;
    strb.shiftIn     = rise;
    strb.shiftOut    = fall & (bitCnt != '0);
    strb.loadFromCpu = cpuTx & ~txFull & shEmpty & (bitCnt == '0);
    strb.writeTxBuf  = cpuTx & ~txFull & ~strb.loadFromCpu;
    strb.loadFromTx  = complete & txFull;
    strb.captureRx   = complete & ~rxFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      ieReg   <= 1'b0;
      modeReg <= MODE_FOUR_WIRE;
      doneF   <= 1'b0;
      wcolF   <= 1'b0;
      ovrF    <= 1'b0;
      rxFull  <= 1'b0;
      txFull  <= 1'b0;
      shEmpty <= 1'b1;
      bitCnt  <= '0;
    end else begin
      if (cpuCtl) begin
        enReg   <= ctlBits[0];
        modeReg <= ctlBits[2:1];
        ieReg   <= ctlBits[3];
      end

      if (!enReg || (!threeWire && nssFall)) bitCnt <= '0;
      else if (rise) bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;

      if (strb.loadFromTx)      txFull <= 1'b0;
      else if (strb.writeTxBuf) txFull <= 1'b1;

      if (strb.loadFromCpu || strb.loadFromTx) shEmpty <= 1'b0;
      else if (complete)                       shEmpty <= 1'b1;

      if (strb.captureRx) rxFull <= 1'b1;
      else if (rxPop)     rxFull <= 1'b0;

      if (complete)                    doneF <= 1'b1;
      else if (cpuCtl && !ctlBits[6])  doneF <= 1'b0;
      if (collide)                     wcolF <= 1'b1;
      else if (cpuCtl && !ctlBits[5])  wcolF <= 1'b0;
      if (complete && rxFull)          ovrF  <= 1'b1;
      else if (cpuCtl && !ctlBits[4])  ovrF  <= 1'b0;
    end
  end

  assign ctrlWord = {doneF, wcolF, ovrF, ieReg, modeReg, txFull, enReg};
  assign irq      = ieReg & (doneF | wcolF | ovrF);

  // R2: a completed byte raises the done flag
  a_r2_done_set: assert property (@(posedge clk) disable iff (!rstN)
    complete |=> doneF);

  // R5: a colliding write raises the collision flag
  a_r5_collision: assert property (@(posedge clk) disable iff (!rstN)
    collide |=> wcolF);

  // R6: overrun flags and keeps the buffer marked full
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (complete && rxFull) |=> (ovrF && rxFull));

  // R10: done only rises after a byte completed
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneF) |-> $past(complete));

  // R11 / R9: a disabled slave holds its counter at zero
  a_r11_idle_count: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> (bitCnt == '0));

  // R7: slave-select high freezes the counter in 4-wire mode
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !threeWire && nssLvl && !cpuCtl) |=> $stable(bitCnt));

endmodule

// File: rtl/spiSlave.sv
module spiSlave
  import spiSlvPkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sckIn,
  input  logic          mosiIn,
  input  logic          nssIn,
  output logic          misoOut,
  output logic          misoEn,
  input  logic          wrEn,
  input  logic          wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic          rdAddr,
  output logic [DW-1:0] rdData,
  output logic          irq
);

  spiStrobeT     strb;
  logic          sckRise, sckFall, nssFall, nssLvl;
  logic [7:0]    ctrlWord;
  logic [DW-1:0] rxWord;

  spiSlvData #(.DW(DW), .SYNC(SYNC)) u_data (
    .clk, .rstN, .sckIn, .mosiIn, .nssIn,
    .strb, .cpuData(wrData),
    .sckRise, .sckFall, .nssFall, .nssLvl,
    .misoBit(misoOut), .rxWord
  );

  spiSlvCtrl #(.DW(DW)) u_ctrl (
    .clk, .rstN, .sckRise, .sckFall, .nssFall, .nssLvl,
    .wrEn, .wrAddr, .ctlBits({wrData[7:2], wrData[0]}),
    .rdEn, .rdAddr,
    .strb, .ctrlWord, .active(misoEn), .irq
  );

  assign rdData = (rdAddr == ADDR_CTRL) ? DW'(ctrlWord) : rxWord;

endmodule

// File: tb/test_spiSlave.sv
module test_spiSlave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sckIn = 1'b0, mosiIn = 1'b0, nssIn = 1'b1;
  logic       misoOut, misoEn, irq;
  logic       wrEn = 1'b0, wrAddr = 1'b0, rdEn = 1'b0, rdAddr = 1'b0;
  logic [7:0] wrData = '0, rdData;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiSlave i_spiSlave (
    .clk, .rstN, .sckIn, .mosiIn, .nssIn, .misoOut, .misoEn,
    .wrEn, .wrAddr, .wrData, .rdEn, .rdAddr, .rdData, .irq
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cpuRead(input logic addr, input bit pop, output logic [7:0] data);
    @(negedge clk);
    rdAddr = addr;
    #1 data = rdData;
    rdEn = pop;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // Sends the top nBits of txByte MSB first; returns data-out samples
  task automatic spiBits(input logic [7:0] txByte, input int nBits, output logic [7:0] rxByte);
    rxByte = '0;
    for (int i = 0; i < nBits; i++) begin
      mosiIn = txByte[7-i];
      waitClk(HALF);
      rxByte = {rxByte[6:0], misoOut};
      sckIn = 1'b1;
      waitClk(HALF);
      sckIn = 1'b0;
    end
    waitClk(HALF);
  endtask

  task automatic testReset();
    logic [7:0] v;
    cpuRead(1'b1, 0, v);
    check("R1 ctrl after reset", v, 8'h04);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
    check("R1 misoEn after reset", {7'd0, misoEn}, 8'h00);
  endtask

  task automatic testBasic();
    logic [7:0] v, m;
    cpuWrite(1'b1, 8'hF5);
    nssIn = 1'b0; waitClk(4);
    cpuWrite(1'b0, 8'hA5);
    cpuRead(1'b1, 0, v);
    check("R3 direct load leaves buffer free", v, 8'h15);
    spiBits(8'h3C, 8, m);
    check("R3 data-out byte", m, 8'hA5);
    cpuRead(1'b1, 0, v);
    check("R2 done flag", v, 8'h95);
    check("R10 irq with done", {7'd0, irq}, 8'h01);
    cpuRead(1'b0, 1, v);
    check("R2 received byte", v, 8'h3C);
    cpuWrite(1'b1, 8'h15);
    cpuRead(1'b1, 0, v);
    check("R10 done cleared by 0", v, 8'h15);
    check("R10 irq cleared", {7'd0, irq}, 8'h00);
  endtask

  task automatic testBuffer();
    logic [7:0] v, m;
    cpuWrite(1'b0, 8'h11);
    cpuWrite(1'b0, 8'h22);
    cpuRead(1'b1, 0, v);
    check("R4 buffer full bit", v, 8'h17);
    cpuWrite(1'b0, 8'h33);
    cpuRead(1'b1, 0, v);
    check("R5 collision flag", v, 8'h57);
    spiBits(8'h01, 8, m);
    check("R4 first byte sent", m, 8'h11);
    cpuRead(1'b1, 0, v);
    check("R4 buffer drained at byte end", v, 8'hD5);
    cpuWrite(1'b1, 8'hF5);
    cpuRead(1'b1, 0, v);
    check("R10 writing 1 keeps flags", v, 8'hD5);
    cpuRead(1'b0, 1, v);
    check("R2 first rx", v, 8'h01);
    spiBits(8'h02, 8, m);
    check("R5 held byte unchanged", m, 8'h22);
    cpuRead(1'b0, 1, v);
    check("R4 second rx", v, 8'h02);
    cpuWrite(1'b1, 8'h15);
  endtask

  task automatic testOverrun();
    logic [7:0] v, m;
    spiBits(8'h5A, 8, m);
    spiBits(8'hC3, 8, m);
    cpuRead(1'b1, 0, v);
    check("R6 overrun flag", v, 8'hB5);
    cpuRead(1'b0, 1, v);
    check("R6 old byte kept", v, 8'h5A);
    cpuWrite(1'b1, 8'h15);
  endtask

  task automatic testFourWire();
    logic [7:0] v, m;
    nssIn = 1'b1; waitClk(HALF);
    check("R7 misoEn low while deselected", {7'd0, misoEn}, 8'h00);
    spiBits(8'hFF, 8, m);
    cpuRead(1'b1, 0, v);
    check("R7 edges ignored while deselected", v, 8'h15);
    nssIn = 1'b0; waitClk(4);
    check("R7 misoEn high when selected", {7'd0, misoEn}, 8'h01);
    spiBits(8'hE0, 3, m);
    nssIn = 1'b1; waitClk(HALF);
    nssIn = 1'b0; waitClk(HALF);
    spiBits(8'h96, 8, m);
    cpuRead(1'b0, 1, v);
    check("R8 select edge realigns byte", v, 8'h96);
    cpuRead(1'b1, 0, v);
    check("R8 single completion", v, 8'h95);
    cpuWrite(1'b1, 8'h15);
  endtask

  task automatic testThreeWire();
    logic [7:0] v, m;
    nssIn = 1'b1;
    cpuWrite(1'b1, 8'h11);
    waitClk(HALF);
    check("R9 misoEn with select high", {7'd0, misoEn}, 8'h01);
    spiBits(8'hA0, 3, m);
    nssIn = 1'b0; waitClk(HALF);
    nssIn = 1'b1; waitClk(HALF);
    spiBits(8'h70, 5, m);
    cpuRead(1'b0, 1, v);
    check("R9 select ignored, bits continue", v, 8'hAE);
    cpuWrite(1'b1, 8'h11);
    spiBits(8'hE0, 3, m);
    cpuWrite(1'b1, 8'h10);
    cpuWrite(1'b1, 8'h11);
    spiBits(8'h4B, 8, m);
    cpuRead(1'b0, 1, v);
    check("R9 enable cycle restarts count", v, 8'h4B);
    cpuRead(1'b1, 0, v);
    check("R9 ctrl after byte", v, 8'h91);
    cpuWrite(1'b1, 8'h11);
  endtask

  task automatic testDisabled();
    logic [7:0] v, m;
    cpuWrite(1'b1, 8'h10);
    check("R11 misoEn low when disabled", {7'd0, misoEn}, 8'h00);
    spiBits(8'hFF, 8, m);
    cpuRead(1'b1, 0, v);
    check("R11 no flags when disabled", v, 8'h10);
    cpuRead(1'b0, 0, v);
    check("R11 receive buffer untouched", v, 8'h4B);
  endtask

  initial begin
    waitClk(3);
    rstN = 1'b1;
    waitClk(3);
    testReset();
    testBasic();
    testBuffer();
    testOverrun();
    testFourWire();
    testThreeWire();
    testDisabled();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule